// File: doc/BRIEF.md
# Transition-Limiting Bus Inversion Encoder

This encoder sits on the transmit side of a 32-line parallel data bus. The bus is treated as two independent 16-line lanes, and each lane has one extra polarity line. For every accepted word, the block compares each lane's new value with the value currently on that lane's wires. If sending the word as it is would switch more than half of the lane's lines, the block sends the bitwise complement instead and raises that lane's polarity line. The receiver recovers the data by XORing each lane with its polarity bit.

Input is a valid strobe with data. The block always accepts a word in the cycle it is offered and has no ready signal, so it never applies back-pressure. The upstream source may present a new word every cycle. All wire outputs and the output strobe come from registers, with one cycle of latency. An enable input switches the inversion logic on. When it is low, words pass through unchanged with both polarity lines low.

Top module: `bie_encoder`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted word, the bus data reads all zeros, both polarity lines read 0, and the output strobe reads 0.
- R2: With enable high, a lane whose new value differs from the lane's current wire value in more than 8 of its 16 lines is driven as the bitwise complement on the next cycle, and its polarity line is 1.
- R3: With enable high, a lane whose new value differs from the current wire value in exactly 8 lines is driven true, and its polarity line is 0.
- R4: With enable high, a lane whose new value differs in fewer than 8 lines is driven true, and its polarity line is 0.
- R5: With enable high, no accepted word switches more than 8 lines of either lane relative to the previous wire value.
- R6: With enable low, the accepted word appears on the bus unchanged on the next cycle, and both polarity lines are 0.
- R7: The two lanes decide independently: bits [15:0] use polarity line 0, and bits [31:16] use polarity line 1.
- R8: In a cycle where the input strobe is low, the bus data and polarity lines keep their previous values.
- R9: The output strobe is the input strobe delayed by one clock. Every accepted word produces exactly one output strobe.
- R10: For every accepted word, XORing each lane of the bus data with its polarity bit gives back the accepted word.
- R11: The comparison uses the values actually driven on the wires, after any inversion. Sending the same word twice in a row after an inverted transfer inverts it again, so the wires do not switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 enables inversion, 0 passes data through |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 32 | Input word |
| bus_data | output | 32 | Registered wire values |
| bus_flag | output | 2 | Registered per-lane polarity lines, 1 means inverted |
| bus_valid | output | 1 | Registered output strobe |

## Verification
The bench builds the block with its default parameters: two lanes of 16 lines. This gives a threshold of 8, so the exact-tie and nine-line boundaries can be reached with hand-picked words. The directed words cover a complemented lane beside an untouched lane, a repeated word after inversion, and the 8- and 9-toggle boundaries. A long pseudo-random stream with enable toggling and idle gaps follows. Each output is decoded and its toggle count measured against the previous wire state.

// File: rtl/bie_pkg.sv
package bie_pkg;
  typedef enum logic {
    DRIVE_TRUE = 1'b0,
    DRIVE_INV  = 1'b1
  } polarity_e;

  function automatic int unsigned half_of(input int unsigned w);
    return w / 2;
  endfunction
endpackage

// File: rtl/bie_popcount.sv
module bie_popcount #(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < int'(W); i++) begin
      count = count + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/bie_lane.sv
module bie_lane
  import bie_pkg::*;
#(
  parameter int unsigned LANE_W = 16
) (
  input  logic              enable,
  input  logic [LANE_W-1:0] cand,
  input  logic [LANE_W-1:0] prev_wire,
  output logic [LANE_W-1:0] wire_next,
  output polarity_e         pol
);
  localparam int unsigned CW   = $clog2(LANE_W + 1);
  localparam int unsigned HALF = half_of(LANE_W);

  logic [CW-1:0] toggles;

  bie_popcount #(.W(LANE_W)) u_cnt (
    .vec   (cand ^ prev_wire),
    .count (toggles)
  );

  always_comb begin
    // a tie at exactly HALF stays true
    if (enable && (toggles > CW'(HALF))) begin
      pol       = DRIVE_INV;
      wire_next = ~cand;
    end else begin
      pol       = DRIVE_TRUE;
      wire_next = cand;
    end
  end
endmodule

// File: rtl/bie_encoder.sv
module bie_encoder
  import bie_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] bus_data,
  output logic [LANES-1:0]  bus_flag,
  output logic              bus_valid
);
  logic [DATA_W-1:0] wire_q;
  logic [LANES-1:0]  flag_q;
  logic              valid_q;
  logic [DATA_W-1:0] wire_d;
  logic [LANES-1:0]  flag_d;

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    polarity_e pol;
    bie_lane #(.LANE_W(LANE_W)) u_lane (
      .enable    (enable),
      .cand      (in_data[g*LANE_W +: LANE_W]),
      .prev_wire (wire_q[g*LANE_W +: LANE_W]),
      .wire_next (wire_d[g*LANE_W +: LANE_W]),
      .pol       (pol)
    );
    assign flag_d[g] = (pol == DRIVE_INV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wire_q  <= '0;
      flag_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        wire_q <= wire_d;
        flag_q <= flag_d;
      end
    end
  end

  assign bus_data  = wire_q;
  assign bus_flag  = flag_q;
  assign bus_valid = valid_q;
endmodule

// File: rtl/bie_encoder_chk.sv
module bie_encoder_chk #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned HALF   = LANE_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic [DATA_W-1:0] bus_data,
  input logic [LANES-1:0]  bus_flag,
  input logic              bus_valid
);
  logic [DATA_W-1:0] flag_mask;
  always_comb begin
    for (int i = 0; i < int'(DATA_W); i++) flag_mask[i] = bus_flag[i / int'(LANE_W)];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (bus_data == '0 && bus_flag == '0 && !bus_valid)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(bus_data) && $stable(bus_flag))); // R8
  AST_STROBE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> bus_valid); // R9
  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !bus_valid); // R9
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !enable) |=> (bus_flag == '0 && bus_data == $past(in_data))); // R6
  AST_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((bus_data ^ flag_mask) == $past(in_data))); // R10

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane_chk
    AST_TOGGLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enable) |=>
        ($countones(bus_data[g*LANE_W +: LANE_W] ^ $past(bus_data[g*LANE_W +: LANE_W])) <= HALF)); // R5
    AST_INVERT_OVER: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enable &&
       $countones(in_data[g*LANE_W +: LANE_W] ^ bus_data[g*LANE_W +: LANE_W]) > HALF) |=> bus_flag[g]); // R2
    AST_TIE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enable &&
       $countones(in_data[g*LANE_W +: LANE_W] ^ bus_data[g*LANE_W +: LANE_W]) == HALF) |=> !bus_flag[g]); // R3
  end
endmodule

bind bie_encoder bie_encoder_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .bus_data  (bus_data),
  .bus_flag  (bus_flag),
  .bus_valid (bus_valid)
);

// File: tb/bie_encoder_test.sv
module bie_encoder_test;
  localparam int LANES  = 2;
  localparam int LANE_W = 16;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, enable, in_valid;
  logic [DATA_W-1:0] in_data, bus_data;
  logic [LANES-1:0]  bus_flag;
  logic              bus_valid;

  bie_encoder #(.LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
    .in_data(in_data), .bus_data(bus_data), .bus_flag(bus_flag), .bus_valid(bus_valid)
  );

  typedef struct packed {
    logic [DATA_W-1:0] wires;
    logic [LANES-1:0]  flags;
    logic [DATA_W-1:0] orig;
    logic [DATA_W-1:0] prev;
    logic              en;
  } item_t;

  item_t             sb[$];
  int                checks = 0, failures = 0;
  logic [DATA_W-1:0] model_wire = '0;
  logic [DATA_W-1:0] seen_data = '0;
  logic [LANES-1:0]  seen_flag = '0;
  logic              mon_on = 1'b0;
  logic              done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: computes the expected wires from the requirements and queues them
  task automatic send(input logic [DATA_W-1:0] d, input logic en);
    item_t e;
    @(negedge clk);
    enable = en; in_valid = 1'b1; in_data = d;
    e.orig = d; e.prev = model_wire; e.en = en;
    for (int g = 0; g < LANES; g++) begin
      logic [LANE_W-1:0] c, p;
      c = d[g*LANE_W +: LANE_W];
      p = model_wire[g*LANE_W +: LANE_W];
      e.flags[g] = en && ($countones(c ^ p) > LANE_W / 2);
      e.wires[g*LANE_W +: LANE_W] = e.flags[g] ? ~c : c;
    end
    model_wire = e.wires;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (bus_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R9", "strobe without accepted word", {31'd0, bus_valid}, '0);
        end else begin
          item_t e;
          e = sb.pop_front();
          chk(bus_flag == e.flags, "R7", "lane flags", {30'd0, bus_flag}, {30'd0, e.flags});
          for (int g = 0; g < LANES; g++) begin
            int    t, dt;
            string tag;
            logic [LANE_W-1:0] a, x, dec;
            t = $countones(e.orig[g*LANE_W +: LANE_W] ^ e.prev[g*LANE_W +: LANE_W]);
            if (!e.en) tag = "R6";
            else if (t > LANE_W / 2) tag = "R2";
            else if (t == LANE_W / 2) tag = "R3";
            else tag = "R4";
            a = bus_data[g*LANE_W +: LANE_W];
            x = e.wires[g*LANE_W +: LANE_W];
            chk(a == x, tag, "lane wires", {16'd0, a}, {16'd0, x});
            dec = a ^ {LANE_W{bus_flag[g]}};
            chk(dec == e.orig[g*LANE_W +: LANE_W], "R10", "decoded lane",
                {16'd0, dec}, {16'd0, e.orig[g*LANE_W +: LANE_W]});
            if (e.en) begin
              dt = $countones(a ^ e.prev[g*LANE_W +: LANE_W]);
              chk(dt <= LANE_W / 2, "R5", "lane toggles", dt, LANE_W / 2);
            end
          end
        end
      end else begin
        chk(bus_data == seen_data && bus_flag == seen_flag, "R8", "idle hold",
            bus_data, seen_data);
      end
      seen_data = bus_data;
      seen_flag = bus_flag;
    end
  end

  initial begin
    logic [DATA_W-1:0] lfsr;
    rst_n = 1'b0; enable = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_data == '0 && bus_flag == '0 && !bus_valid, "R1", "reset state",
        {bus_data[31:3], bus_flag, bus_valid}, '0);
    mon_on = 1'b1;

    send(32'h0000_FFFF, 1'b1);   // R7: lane0 inverts, lane1 untouched
    send(32'h0000_FFFF, 1'b1);   // R11: inverted again, wires unchanged
    idle(2);
    send(32'h00FF_00FF, 1'b1);   // R3: exactly 8 toggles in each lane
    send(32'h01FF_01FF, 1'b1);   // R4: single toggle
    send(32'hFE00_FE00, 1'b1);   // R2: 16 toggles
    send(32'h0000_0000, 1'b1);   // R2: 9 toggles against 01FF wires
    idle(3);
    send(32'hFFFF_0000, 1'b0);   // R6: pass-through
    send(32'h1234_5678, 1'b0);   // R6
    idle(1);

    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr, (i % 7) != 3);
      if (lfsr[4:3] == 2'b00) idle(1 + int'(lfsr[6:5]));
    end
    idle(4);
    chk(sb.size() == 0, "R9", "every word produced one strobe", sb.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule